// File: doc/BRIEF.md
# Three-Head Nozzle Redundancy Router

This block drives one group of three printheads that sit one behind another along the direction the substrate moves. In each image line, one head is the printing head. The other two are spare heads that listen, which means their piezo elements are used as sensors.

For every line it receives, the block takes the requested pixel vector for the group and looks up three stored per-nozzle fail maps, one for each head. Each requested pixel is steered to the first healthy nozzle at that position, in the order printing head, then the next head, then the one after that. A pixel whose nozzle has failed on all three heads is dropped and counted.

Because the heads are staggered, the fire vector for head h reaches its output h×gap lines later than the line it came from. This lets a pixel land on the same spot whichever head fires it. Any nozzle that is not firing on a spare head is reported as listening. The printing role rotates on request, but only at a line boundary.

Top module: `nozzle_reroute`

## Requirements
- R1: After reset, all fire and listen outputs are zero, `print_head` is 0, `drop_count` is 0 and `out_valid` is 0.
- R2: With p0 as the printing head used for a line, p1 = (p0+1) mod 3 and p2 = (p1+1) mod 3, a requested pixel i fires on p0 if fail map p0 bit i is 0. Otherwise it fires on p1 if map p1 bit i is 0. Otherwise it fires on p2 if map p2 bit i is 0.
- R3: An unrequested pixel fires on no head, and a requested pixel is routed to at most one head.
- R4: A requested pixel whose bit is 1 in all three fail maps fires nowhere. `drop_count` then rises by the number of such pixels in the line, and it saturates at its all-ones value.
- R5: With `fail_we` high, `fail_sel` values 0, 1 and 2 replace the map of that head. A line presented in the same cycle still uses the old map. `fail_sel` = 3 changes no map.
- R6: A pulse on `rotate_req` makes the first line presented in or after that cycle use the next head (0→1→2→0) as its printing head. Several pulses before that line count as one. `print_head` shows the head used by the latest line.
- R7: The fire output of head h shows the routed vector for head h from the line h×`gap` lines before the latest one, and zero when that line came before reset.
- R8: The printing head of the latest line listens on no nozzle. Each spare head listens on exactly the nozzles it does not fire, so no nozzle both fires and listens.
- R9: Fire, listen, `print_head` and `drop_count` change only in the cycle after `line_valid` is high. `out_valid` is high exactly in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | A new line is presented this cycle |
| line_data | input | NOZ | Requested pixels for the group |
| gap | input | GAP_W | Head spacing in lines |
| rotate_req | input | 1 | Request to advance the printing role |
| fail_we | input | 1 | Fail map write strobe |
| fail_sel | input | 2 | Head whose map is written (3 = none) |
| fail_map | input | NOZ | New fail map, 1 = failed nozzle |
| fire0 | output | NOZ | Fire vector, head 0 |
| fire1 | output | NOZ | Fire vector, head 1 |
| fire2 | output | NOZ | Fire vector, head 2 |
| listen0 | output | NOZ | Listen mask, head 0 |
| listen1 | output | NOZ | Listen mask, head 1 |
| listen2 | output | NOZ | Listen mask, head 2 |
| print_head | output | 2 | Printing head of the latest line |
| drop_count | output | CNT_W | Saturating count of dropped pixels |
| out_valid | output | 1 | Outputs refreshed this cycle |

## Verification
The assertions assume that `gap` does not exceed MAXGAP and that `rst_n` is low for at least one clock edge before any line arrives. The rotation check also assumes that `print_head` only ever holds 0, 1 or 2.

The stimulus keeps `gap` inside 0 to 3 and changes it only between lines. Random fail maps are drawn sparse so that all three routing tiers are used, and directed all-ones maps drive the drop counter into saturation. Rotate requests and map writes are sometimes placed in the same cycle as a line, to test the same-cycle ordering.

// File: rtl/nozzle_reroute.sv
module nozzle_reroute #(
  parameter int NOZ    = 256,
  parameter int MAXGAP = 3,
  parameter int GAP_W  = 2,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_valid,
  input  logic [NOZ-1:0]   line_data,
  input  logic [GAP_W-1:0] gap,
  input  logic             rotate_req,
  input  logic             fail_we,
  input  logic [1:0]       fail_sel,
  input  logic [NOZ-1:0]   fail_map,
  output logic [NOZ-1:0]   fire0,
  output logic [NOZ-1:0]   fire1,
  output logic [NOZ-1:0]   fire2,
  output logic [NOZ-1:0]   listen0,
  output logic [NOZ-1:0]   listen1,
  output logic [NOZ-1:0]   listen2,
  output logic [1:0]       print_head,
  output logic [CNT_W-1:0] drop_count,
  output logic             out_valid
);
  localparam int PCW = $clog2(NOZ + 1);
  localparam int D2  = 2 * MAXGAP;
  localparam int SW  = CNT_W + PCW;

  function automatic logic [1:0] nxt(input logic [1:0] h);
    return (h == 2'd2) ? 2'd0 : h + 2'd1;
  endfunction

  function automatic logic [NOZ-1:0] pick(input logic [1:0] h, input logic [NOZ-1:0] a,
                                          input logic [NOZ-1:0] b, input logic [NOZ-1:0] c);
    return (h == 2'd0) ? a : (h == 2'd1) ? b : c;
  endfunction

  function automatic logic [PCW-1:0] popc(input logic [NOZ-1:0] v);
    logic [PCW-1:0] s = '0;
    for (int i = 0; i < NOZ; i++) s = s + PCW'(v[i]);
    return s;
  endfunction

  logic [NOZ-1:0] fm0, fm1, fm2;
  logic [1:0]     prim;
  logic           rot_pend;
  logic [NOZ-1:0] hist1 [MAXGAP];
  logic [NOZ-1:0] hist2 [D2];
  logic [NOZ-1:0] fire_q [3];
  logic [NOZ-1:0] lis_q  [3];
  logic [NOZ-1:0] rt  [3];
  logic [NOZ-1:0] tap [3];

  wire [1:0] p0 = (rotate_req | rot_pend) ? nxt(prim) : prim;
  wire [1:0] p1 = nxt(p0);
  wire [1:0] p2 = nxt(p1);

  wire [NOZ-1:0] m0 = pick(p0, fm0, fm1, fm2);
  wire [NOZ-1:0] m1 = pick(p1, fm0, fm1, fm2);
  wire [NOZ-1:0] m2 = pick(p2, fm0, fm1, fm2);

  wire [NOZ-1:0] use0 = line_data & ~m0;
  wire [NOZ-1:0] use1 = line_data &  m0 & ~m1;
  wire [NOZ-1:0] use2 = line_data &  m0 &  m1 & ~m2;
  wire [NOZ-1:0] drop = line_data & fm0 & fm1 & fm2;

  wire [GAP_W-1:0] gc = (int'(gap) > MAXGAP) ? GAP_W'(MAXGAP) : gap;

  for (genvar h = 0; h < 3; h++) begin : g_route
    assign rt[h] = ({NOZ{p0 == 2'(h)}} & use0) |
                   ({NOZ{p1 == 2'(h)}} & use1) |
                   ({NOZ{p2 == 2'(h)}} & use2);
  end

  always_comb begin
    tap[0] = rt[0];
    tap[1] = rt[1];
    tap[2] = rt[2];
    for (int k = 1; k <= MAXGAP; k++) begin
      if (int'(gc) == k) begin
        tap[1] = hist1[k-1];
        tap[2] = hist2[2*k-1];
      end
    end
  end

  wire [SW-1:0] sum = SW'(drop_count) + SW'(popc(drop));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fm0 <= '0; fm1 <= '0; fm2 <= '0;
      prim <= 2'd0;
      rot_pend <= 1'b0;
      out_valid <= 1'b0;
      drop_count <= '0;
      for (int k = 0; k < MAXGAP; k++) hist1[k] <= '0;
      for (int k = 0; k < D2; k++) hist2[k] <= '0;
      for (int h = 0; h < 3; h++) begin
        fire_q[h] <= '0;
        lis_q[h]  <= '0;
      end
    end else begin
      out_valid <= line_valid;
      if (fail_we) begin
        case (fail_sel)
          2'd0:    fm0 <= fail_map;
          2'd1:    fm1 <= fail_map;
          2'd2:    fm2 <= fail_map;
          default: ;
        endcase
      end
      if (rotate_req) rot_pend <= 1'b1;
      if (line_valid) begin
        prim <= p0;
        rot_pend <= 1'b0;
        hist1[0] <= rt[1];
        for (int k = 1; k < MAXGAP; k++) hist1[k] <= hist1[k-1];
        hist2[0] <= rt[2];
        for (int k = 1; k < D2; k++) hist2[k] <= hist2[k-1];
        for (int h = 0; h < 3; h++) begin
          fire_q[h] <= tap[h];
          lis_q[h]  <= (p0 == 2'(h)) ? '0 : ~tap[h];
        end
        drop_count <= (sum > SW'({CNT_W{1'b1}})) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
      end
    end
  end

  assign fire0 = fire_q[0];
  assign fire1 = fire_q[1];
  assign fire2 = fire_q[2];
  assign listen0 = lis_q[0];
  assign listen1 = lis_q[1];
  assign listen2 = lis_q[2];
  assign print_head = prim;

  // R8
  no_fire_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fire0 & listen0) | (fire1 & listen1) | (fire2 & listen2)) == '0);

  // R6
  head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    print_head != 2'd3);

  // R6
  rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && (rotate_req || rot_pend)) |=> print_head != $past(print_head));

  // R4
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> drop_count >= $past(drop_count));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_valid |=> (!out_valid && $stable(fire0) && $stable(fire1) && $stable(fire2)
                     && $stable(print_head) && $stable(drop_count)));

  // R9
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |=> out_valid);
endmodule

// File: tb/nozzle_reroute_tb.sv
`timescale 1ns/1ps
module nozzle_reroute_tb;
  localparam int N = 256;

  logic clk = 0, rst_n = 0;
  logic line_valid = 0, rotate_req = 0, fail_we = 0;
  logic [N-1:0] line_data = '0, fail_map = '0;
  logic [1:0] gap = 0, fail_sel = 0;
  logic [N-1:0] fire0, fire1, fire2, listen0, listen1, listen2;
  logic [1:0] print_head;
  logic [15:0] drop_count;
  logic out_valid;

  always #4 clk = ~clk;

  nozzle_reroute u_dut (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_data(line_data),
    .gap(gap), .rotate_req(rotate_req), .fail_we(fail_we), .fail_sel(fail_sel),
    .fail_map(fail_map), .fire0(fire0), .fire1(fire1), .fire2(fire2),
    .listen0(listen0), .listen1(listen1), .listen2(listen2),
    .print_head(print_head), .drop_count(drop_count), .out_valid(out_valid));

  int checks = 0, errors = 0;
  logic [N-1:0] mf [3];
  int mprim = 0;
  bit mpend = 0;
  int mcnt = 0;
  int nline = 0;
  logic [N-1:0] r0 [0:2047];
  logic [N-1:0] r1 [0:2047];
  logic [N-1:0] r2 [0:2047];

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] rnd();
    logic [N-1:0] v;
    for (int k = 0; k < N/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic send(input logic [N-1:0] d, input bit rot, input bit wr,
                      input logic [1:0] sel, input logic [N-1:0] m, input string tag);
    logic [N-1:0] e [3];
    logic [N-1:0] ef [3];
    logic [N-1:0] el [3];
    int p, q, s, g, dr;
    @(negedge clk);
    line_valid = 1; line_data = d; rotate_req = rot;
    fail_we = wr; fail_sel = sel; fail_map = m;
    p = (mpend || rot) ? (mprim + 1) % 3 : mprim;
    q = (p + 1) % 3; s = (q + 1) % 3;
    for (int h = 0; h < 3; h++) e[h] = '0;
    dr = 0;
    for (int i = 0; i < N; i++) begin
      if (d[i]) begin
        if (!mf[p][i]) e[p][i] = 1'b1;
        else if (!mf[q][i]) e[q][i] = 1'b1;
        else if (!mf[s][i]) e[s][i] = 1'b1;
        else dr++;
      end
    end
    r0[nline] = e[0]; r1[nline] = e[1]; r2[nline] = e[2];
    g = gap;
    ef[0] = e[0];
    ef[1] = (nline - g >= 0) ? r1[nline - g] : '0;
    ef[2] = (nline - 2*g >= 0) ? r2[nline - 2*g] : '0;
    for (int h = 0; h < 3; h++) el[h] = (h == p) ? '0 : ~ef[h];
    mcnt = (mcnt + dr > 65535) ? 65535 : mcnt + dr;
    mprim = p; mpend = 0;
    if (wr && sel != 2'd3) mf[sel] = m;
    nline++;
    @(negedge clk);
    line_valid = 0; rotate_req = 0; fail_we = 0;
    // R2 R3 R7
    chk(fire0 == ef[0], {"R2 R3 R7 fire0 ", tag}, fire0, ef[0]);
    chk(fire1 == ef[1], {"R2 R3 R7 fire1 ", tag}, fire1, ef[1]);
    chk(fire2 == ef[2], {"R2 R3 R7 fire2 ", tag}, fire2, ef[2]);
    // R8
    chk({listen0, listen1, listen2} == {el[0], el[1], el[2]}, {"R8 listen ", tag}, listen0, el[0]);
    // R6
    chk(print_head == 2'(p), {"R6 print_head ", tag}, N'(print_head), N'(p));
    // R4
    chk(drop_count == 16'(mcnt), {"R4 drop_count ", tag}, N'(drop_count), N'(mcnt));
    // R9
    chk(out_valid == 1'b1, {"R9 out_valid ", tag}, N'(out_valid), N'(1));
  endtask

  task automatic idle_check(input string tag);
    logic [N-1:0] f0;
    f0 = fire0;
    @(negedge clk);
    // R9
    chk(!out_valid && fire0 == f0, {"R9 idle ", tag}, N'(out_valid), '0);
  endtask

  task automatic poke(input bit rot, input bit wr, input logic [1:0] sel, input logic [N-1:0] m);
    @(negedge clk);
    rotate_req = rot; fail_we = wr; fail_sel = sel; fail_map = m;
    if (rot) mpend = 1;
    if (wr && sel != 2'd3) mf[sel] = m;
    @(negedge clk);
    rotate_req = 0; fail_we = 0;
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] a, b;
    void'($urandom(32'd4242));
    for (int h = 0; h < 3; h++) mf[h] = '0;
    repeat (3) @(negedge clk);
    // R1
    chk({fire0, fire1, fire2, listen0, listen1, listen2} == '0, "R1 vectors", fire0, '0);
    chk(print_head == 0 && drop_count == 0 && out_valid == 0, "R1 state", N'(drop_count), '0);
    rst_n = 1;
    @(negedge clk);
    gap = 0;
    send({N{1'b1}}, 0, 0, 0, '0, "healthy");
    idle_check("after healthy");
    a = rnd();
    poke(0, 1, 2'd0, a);
    send({N{1'b1}}, 0, 0, 0, '0, "R2 tier1");
    b = rnd();
    poke(0, 1, 2'd1, a & b);
    send({N{1'b1}}, 0, 0, 0, '0, "R2 tier2");
    poke(0, 1, 2'd2, a & b & rnd());
    send({N{1'b1}}, 0, 0, 0, '0, "R4 drop");
    send(rnd(), 0, 0, 0, '0, "R3 sparse");
    // R5 same-cycle write uses old map
    send({N{1'b1}}, 0, 1, 2'd0, {N{1'b1}}, "R5 same cycle");
    send({N{1'b1}}, 0, 0, 0, '0, "R5 after write");
    // R5 sel 3 ignored
    poke(0, 1, 2'd3, '0);
    send({N{1'b1}}, 0, 0, 0, '0, "R5 sel3");
    for (int h = 0; h < 3; h++) poke(0, 1, 2'(h), '0);
    // R6 collapse and same cycle
    poke(1, 0, 0, '0);
    poke(1, 0, 0, '0);
    send(rnd(), 0, 0, 0, '0, "R6 collapsed");
    send(rnd(), 1, 0, 0, '0, "R6 same cycle");
    send(rnd(), 0, 0, 0, '0, "R6 steady");
    // R7 spacing
    gap = 2;
    for (int k = 0; k < 8; k++) send(rnd(), k % 3 == 0, 0, 0, '0, "R7 gap2");
    for (int it = 0; it < 500; it++) begin
      if (it % 100 == 0) begin
        gap = 2'($urandom % 4);
        @(negedge clk);
      end
      if ($urandom % 7 == 0) poke($urandom % 2, 1, 2'($urandom % 4), rnd() & rnd() & rnd());
      send(rnd(), $urandom % 8 == 0, $urandom % 5 == 0, 2'($urandom % 4),
           rnd() & rnd() & rnd(), "random");
    end
    // R4 saturation
    for (int h = 0; h < 3; h++) poke(0, 1, 2'(h), {N{1'b1}});
    for (int k = 0; k < 260; k++) send({N{1'b1}}, 0, 0, 0, '0, "R4 saturate");
    chk(drop_count == 16'hFFFF, "R4 saturated", N'(drop_count), N'(16'hFFFF));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule